// File: doc/BRIEF.md
# Page Address Translator with Associative Translation Buffer

This block turns a logical address into a physical address. The logical address has two parts. The upper bits are a virtual page number, and the lower bits are an offset within the page. The offset is copied straight into the physical address. The page number is replaced by a physical frame number.

Recent translations are kept in a small, fully associative translation buffer. A request that hits in the buffer is answered on the next cycle, without any memory traffic. On a miss, the block reads one page-table entry through a simple read port and waits for the data. If the entry marks the page as resident, the translation is written into the buffer and returned. If the page is not resident, the block returns a page-fault indication instead of an address.

A flush input empties the buffer. Two saturating counters record hits and misses.

Top module: `page_xlate`

## Requirements
- R1: With an offset width of OFF_W, the physical address is the frame number in bits PA_W-1:OFF_W and the unchanged logical offset in bits OFF_W-1:0. The page number is logical bits VA_W-1:OFF_W.
- R2: A request whose page is held in the buffer gets `resp_valid_o` high on the cycle after it is accepted. No page-table read is issued for it.
- R3: On a miss, `pt_rd_o` pulses for exactly one cycle with `pt_addr_o` equal to `pt_base_i` plus the page number. The block then waits any number of cycles for `pt_rvalid_i`.
- R4: A page-table entry is PFN_W+1 bits wide. Bit PFN_W is the resident flag, and bits PFN_W-1:0 are the frame number. A cleared flag produces `resp_fault_o` = 1 with `resp_paddr_o` = 0.
- R5: A faulting translation is never cached. Repeating the same non-resident page starts a new page-table read every time.
- R6: A resident miss fills the buffer before the response is returned. Buffer slots are replaced in round-robin order, so the (ENTRIES+1)th distinct fill evicts the oldest fill. A page is never held in two slots.
- R7: A one-cycle `flush_i` pulse invalidates every buffer entry, so each previously cached page misses afterwards.
- R8: If `flush_i` is seen during any cycle of a page-table walk, that walk's result is returned but not cached.
- R9: Only one request is in flight at a time: `req_ready_o` is low from acceptance until the response is taken. While `resp_ready_i` is low, the response stays valid and unchanged.
- R10: `hit_cnt_o` counts accepted requests that hit, and `miss_cnt_o` counts accepted requests that miss. Each counter saturates at all-ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Invalidate all buffer entries |
| pt_base_i | input | PT_AW | Page-table base address |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Block can accept a request |
| req_vaddr_i | input | VA_W | Logical address |
| resp_valid_o | output | 1 | Response valid |
| resp_ready_i | input | 1 | Response taken |
| resp_paddr_o | output | PA_W | Physical address (0 on fault) |
| resp_fault_o | output | 1 | Page not resident |
| pt_rd_o | output | 1 | Page-table read strobe |
| pt_addr_o | output | PT_AW | Page-table entry address |
| pt_rvalid_i | input | 1 | Page-table read data valid |
| pt_rdata_i | input | PFN_W+1 | Page-table entry: resident flag and frame |
| hit_cnt_o | output | CNT_W | Saturating hit count |
| miss_cnt_o | output | CNT_W | Saturating miss count |

## Verification
The bench targets the following corner cases, each paired with the fault it would expose:

- A faulting page is requested twice. A design that cached faults would skip the second walk and answer as a hit.
- Exactly one more distinct resident page than there are buffer slots is filled. The bench then revisits the oldest page and a neighbour. A wrong replacement order would evict the wrong page, or none at all.
- A flush arrives while a walk is in progress. A design that ignored it would install a stale entry, and the next access would hit.
- A response is held under backpressure. A design that dropped it, changed it, or took a new request during the hold would be caught.
- A long run of hits drives the hit counter to all-ones. Wrap-around instead of saturation shows up there.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD,
    ST_WAIT,
    ST_RESP
  } xl_state_e;
endpackage

// File: rtl/xlate_tlb.sv
module xlate_tlb #(
  parameter int ENTRIES = 32,
  parameter int TAG_W   = 20,
  parameter int DATA_W  = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [TAG_W-1:0]  lk_tag_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] hit_data_o,
  input  logic              fill_i,
  input  logic [TAG_W-1:0]  fill_tag_i,
  input  logic [DATA_W-1:0] fill_data_i
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld_q;
  logic [ENTRIES-1:0] match;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [DATA_W-1:0]  data_q [ENTRIES];
  logic [IDX_W-1:0]   rr_q;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign match[g] = vld_q[g] && (tag_q[g] == lk_tag_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tag_q[g]  <= '0;
        data_q[g] <= '0;
      end else if (fill_i && (rr_q == IDX_W'(g))) begin
        tag_q[g]  <= fill_tag_i;
        data_q[g] <= fill_data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
    end else if (flush_i) begin
      vld_q <= '0;
    end else if (fill_i) begin
      for (int i = 0; i < ENTRIES; i++)
        if (rr_q == IDX_W'(i)) vld_q[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rr_q <= '0;
    else if (fill_i && !flush_i)
      rr_q <= (rr_q == IDX_W'(ENTRIES-1)) ? '0 : rr_q + 1'b1;
  end

  assign hit_o = |match;

  always_comb begin
    hit_data_o = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match[i]) hit_data_o = hit_data_o | data_q[i];
  end

  // R6
  match_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match));

  // R7
  flush_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !hit_o);
endmodule

// File: rtl/sat_cnt.sv
module sat_cnt #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else if (inc_i && (cnt_o != '1)) cnt_o <= cnt_o + 1'b1;
  end

  // R10
  cnt_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> cnt_o >= $past(cnt_o));

  // R10
  cnt_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == '1) |=> (cnt_o == '1));
endmodule

// File: rtl/page_xlate.sv
module page_xlate
  import xlate_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int ENTRIES = 32,
  parameter int PT_AW   = 32,
  parameter int CNT_W   = 32,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int PFN_W  = PA_W - OFF_W,
  localparam int PTE_W  = PFN_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [PT_AW-1:0] pt_base_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VA_W-1:0]  req_vaddr_i,
  output logic             resp_valid_o,
  input  logic             resp_ready_i,
  output logic [PA_W-1:0]  resp_paddr_o,
  output logic             resp_fault_o,
  output logic             pt_rd_o,
  output logic [PT_AW-1:0] pt_addr_o,
  input  logic             pt_rvalid_i,
  input  logic [PTE_W-1:0] pt_rdata_i,
  output logic [CNT_W-1:0] hit_cnt_o,
  output logic [CNT_W-1:0] miss_cnt_o
);
  xl_state_e         state_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [OFF_W-1:0]  off_q;
  logic [PA_W-1:0]   paddr_q;
  logic              fault_q;
  logic              flushed_q;

  logic              accept;
  logic              tlb_hit;
  logic [PFN_W-1:0]  tlb_pfn;
  logic              pte_res;
  logic              fill;

  assign accept  = req_valid_i && (state_q == ST_IDLE);
  assign pte_res = pt_rdata_i[PFN_W];
  // fill skipped if a flush was seen anywhere in this walk
  assign fill    = (state_q == ST_WAIT) && pt_rvalid_i && pte_res && !flushed_q && !flush_i;

  xlate_tlb #(
    .ENTRIES (ENTRIES),
    .TAG_W   (VPN_W),
    .DATA_W  (PFN_W)
  ) u_tlb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_i),
    .lk_tag_i    (req_vaddr_i[VA_W-1:OFF_W]),
    .hit_o       (tlb_hit),
    .hit_data_o  (tlb_pfn),
    .fill_i      (fill),
    .fill_tag_i  (vpn_q),
    .fill_data_i (pt_rdata_i[PFN_W-1:0])
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      vpn_q     <= '0;
      off_q     <= '0;
      paddr_q   <= '0;
      fault_q   <= 1'b0;
      flushed_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          vpn_q     <= req_vaddr_i[VA_W-1:OFF_W];
          off_q     <= req_vaddr_i[OFF_W-1:0];
          flushed_q <= 1'b0;
          if (tlb_hit) begin
            paddr_q <= {tlb_pfn, req_vaddr_i[OFF_W-1:0]};
            fault_q <= 1'b0;
            state_q <= ST_RESP;
          end else begin
            state_q <= ST_RD;
          end
        end
        ST_RD: begin
          if (flush_i) flushed_q <= 1'b1;
          state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (flush_i) flushed_q <= 1'b1;
          if (pt_rvalid_i) begin
            paddr_q <= pte_res ? {pt_rdata_i[PFN_W-1:0], off_q} : '0;
            fault_q <= !pte_res;
            state_q <= ST_RESP;
          end
        end
        ST_RESP: if (resp_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o  = (state_q == ST_IDLE);
  assign resp_valid_o = (state_q == ST_RESP);
  assign resp_paddr_o = paddr_q;
  assign resp_fault_o = fault_q;
  assign pt_rd_o      = (state_q == ST_RD);
  assign pt_addr_o    = pt_base_i + PT_AW'(vpn_q);

  sat_cnt #(.W(CNT_W)) u_hit_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (accept && tlb_hit),
    .cnt_o  (hit_cnt_o)
  );

  sat_cnt #(.W(CNT_W)) u_miss_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (accept && !tlb_hit),
    .cnt_o  (miss_cnt_o)
  );

  // R2
  hit_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && tlb_hit) |=> (resp_valid_o && !pt_rd_o));

  // R3
  pt_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pt_rd_o |=> !pt_rd_o);

  // R9
  resp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && !resp_ready_i) |=>
      (resp_valid_o && $stable(resp_paddr_o) && $stable(resp_fault_o)));

  // R4
  fault_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && resp_fault_o) |-> (resp_paddr_o == '0));
endmodule

// File: tb/tb_page_xlate.sv
`timescale 1ns/1ps
module tb_page_xlate;
  localparam int CNT_W   = 6;
  localparam int ENTRIES = 32;
  localparam logic [31:0] PT_BASE = 32'h0010_0000;
  localparam int NV = 10;
  localparam logic [31:0] V_ADDR [NV] = '{
    32'h0000_1234, 32'h0000_1FFC, 32'h0001_2008, 32'h0000_F010, 32'h0000_F444,
    32'h0001_2FFF, 32'hFFFF_E000, 32'hFFFF_FABC, 32'h0000_0000, 32'h0000_0FFF};
  localparam bit V_WALK [NV] = '{1, 0, 1, 1, 1, 0, 1, 1, 1, 0};
  localparam bit V_FLT  [NV] = '{0, 0, 0, 1, 1, 0, 0, 1, 0, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [31:0] req_vaddr = '0;
  logic resp_valid;
  logic resp_ready = 1'b1;
  logic [31:0] resp_paddr;
  logic resp_fault;
  logic pt_rd;
  logic [31:0] pt_addr;
  logic pt_rvalid = 1'b0;
  logic [20:0] pt_rdata = '0;
  logic [CNT_W-1:0] hit_cnt, miss_cnt;

  int n_chk = 0, n_bad = 0, walk_cnt = 0, exp_hit = 0, exp_miss = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  page_xlate #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .pt_base_i(PT_BASE),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_vaddr_i(req_vaddr),
    .resp_valid_o(resp_valid), .resp_ready_i(resp_ready),
    .resp_paddr_o(resp_paddr), .resp_fault_o(resp_fault),
    .pt_rd_o(pt_rd), .pt_addr_o(pt_addr), .pt_rvalid_i(pt_rvalid),
    .pt_rdata_i(pt_rdata), .hit_cnt_o(hit_cnt), .miss_cnt_o(miss_cnt));

  function automatic logic [19:0] pfn_of(input logic [19:0] v);
    return v ^ 20'hA5A5A;
  endfunction
  function automatic bit res_of(input logic [19:0] v);
    return v[3:0] != 4'hF;
  endfunction
  function automatic logic [31:0] exp_pa(input logic [31:0] va);
    return res_of(va[31:12]) ? {pfn_of(va[31:12]), va[11:0]} : 32'h0;
  endfunction
  function automatic int sat(input int v);
    return (v > (1 << CNT_W) - 1) ? (1 << CNT_W) - 1 : v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // page-table responder: two-cycle read latency
  initial begin : responder
    logic [19:0] v;
    forever begin
      @(negedge clk);
      if (pt_rd) begin
        v = 20'(pt_addr - PT_BASE);
        walk_cnt++;
        repeat (2) @(negedge clk);
        pt_rvalid = 1'b1;
        pt_rdata  = {res_of(v), pfn_of(v)};
        @(negedge clk);
        pt_rvalid = 1'b0;
      end
    end
  end

  task automatic xlate(input logic [31:0] va, output logic [31:0] pa,
                       output logic flt, output int cyc, output bit walked);
    int w0;
    w0 = walk_cnt;
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    while (!resp_valid) begin
      @(negedge clk);
      cyc++;
    end
    pa = resp_paddr;
    flt = resp_fault;
    @(negedge clk);
    walked = (walk_cnt != w0);
    if (walked) exp_miss++; else exp_hit++;
  endtask

  task automatic full(input logic [31:0] va, input bit exp_walk, input string req);
    logic [31:0] pa;
    logic flt;
    int cyc;
    bit w;
    xlate(va, pa, flt, cyc, w);
    check(w == exp_walk, req, 64'(w), 64'(exp_walk));
    check(pa == exp_pa(va), {req, " R1 R4 paddr"}, 64'(pa), 64'(exp_pa(va)));
    check(flt == !res_of(va[31:12]), {req, " R4 fault"}, 64'(flt), 64'(!res_of(va[31:12])));
    if (!exp_walk) check(cyc == 1, {req, " R2 hit latency"}, 64'(cyc), 64'd1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog timeout actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] pa0;
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R9 reset ready", 64'(req_ready), 64'd1);
    check(resp_valid == 1'b0, "R9 reset resp_valid", 64'(resp_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(pt_rd == 1'b0, "R3 reset pt_rd", 64'(pt_rd), 64'd0);
    check(hit_cnt == 0 && miss_cnt == 0, "R10 reset counters", 64'({hit_cnt, miss_cnt}), 64'd0);

    // vector table: R1 R2 R3 R4 R5
    for (int i = 0; i < NV; i++)
      full(V_ADDR[i], V_WALK[i], V_FLT[i] ? "R5 vector" : "R2 R3 vector");

    // R9 backpressure on a hit
    resp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = 32'h0000_0ABC;
    @(negedge clk);
    req_valid = 1'b0;
    check(resp_valid == 1'b1, "R9 hit resp valid", 64'(resp_valid), 64'd1);
    pa0 = resp_paddr;
    req_valid = 1'b1;
    req_vaddr = 32'h0000_1000;
    repeat (3) @(negedge clk);
    check(resp_valid && resp_paddr == pa0, "R9 held", 64'(resp_paddr), 64'(pa0));
    check(pa0 == exp_pa(32'h0000_0ABC), "R9 R1 held value", 64'(pa0), 64'(exp_pa(32'h0000_0ABC)));
    check(req_ready == 1'b0, "R9 ready low while busy", 64'(req_ready), 64'd0);
    req_valid = 1'b0;
    resp_ready = 1'b1;
    exp_hit++;
    @(negedge clk);
    check(resp_valid == 1'b0, "R9 released", 64'(resp_valid), 64'd0);

    // R7 flush
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    full(32'h0000_1234, 1'b1, "R7 flushed page misses");
    full(32'h0001_2008, 1'b1, "R7 flushed page misses");
    full(32'h0000_1234, 1'b0, "R6 refilled page hits");

    // R8 flush during walk
    fork
      full(32'h0000_5000, 1'b1, "R8 walk");
      begin
        repeat (3) @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
      end
    join
    full(32'h0000_5000, 1'b1, "R8 walk result not cached");

    // R6 round-robin replacement
    for (int i = 0; i <= ENTRIES; i++)
      full(32'h0010_0000 + 32'(i) * 32'h0001_0000, 1'b1, "R6 fill");
    full(32'h0010_0000, 1'b1, "R6 oldest evicted");
    full(32'h0012_0000, 1'b0, "R6 third fill kept");
    full(32'h0011_0000, 1'b1, "R6 second fill evicted next");

    check(miss_cnt == sat(exp_miss), "R10 miss count", 64'(miss_cnt), 64'(sat(exp_miss)));
    check(hit_cnt == sat(exp_hit), "R10 hit count", 64'(hit_cnt), 64'(sat(exp_hit)));

    // R10 saturation
    for (int i = 0; i < 70; i++) begin
      logic [31:0] pa;
      logic flt;
      int cyc;
      bit w;
      xlate(32'h0012_0040, pa, flt, cyc, w);
    end
    check(hit_cnt == sat(exp_hit), "R10 hit saturates", 64'(hit_cnt), 64'(sat(exp_hit)));
    check(hit_cnt == {CNT_W{1'b1}}, "R10 hit all-ones", 64'(hit_cnt), 64'({CNT_W{1'b1}}));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule